// File: doc/BRIEF.md
# Opcode-Driven Control Register Decoder

This block sits behind a byte-oriented bus slave front end. It receives messages as a stream of bytes. The first byte of each message is an opcode and the following bytes are its arguments. The block applies each argument byte as it arrives to a 20-entry control register file and a 256-byte lookup table. When a message ends, it raises a one-cycle strobe toward the note timing, PWM and persistence logic.

Reads work through three pointer registers kept in the register file: one for registers, one for the table and one for a stubbed nonvolatile store. A selector register picks which of the three applies. Each read request returns one byte and advances the selected pointer. Writes work the same way, through three write pointers and a destination selector.

Error conditions set sticky bits in an error register, which also drives an output port. Register 14 mirrors a two-bit state input (bit 0 attack, bit 1 hold), and messages cannot write it.

Top module: `cmd_decoder`

## Requirements
- R1: After reset, every register reads 0 except reg7=4, reg8=5, reg10=4, reg11=127, reg12=255, reg13=5, reg16=14 and reg18=250. `err_flags` reads 0, and no strobe or `rd_valid` is high.
- R2: Reads use the source in reg3 (0 = registers via pointer reg0, 1 = table via pointer reg1, 2 = stub via pointer reg2, which always returns 8'hFF). A read request gives `rd_valid` and `rd_data` on the next cycle, and the selected pointer increments by one.
- R3: When reg3 holds 3 or more, a read request produces no `rd_valid` and sets error bit 0 (8'h01).
- R4: Opcode 4 stores argument 0 in reg3. Argument 1, if present, is stored in the pointer register that the new reg3 value selects.
- R5: For opcode 5, argument 0 bits [2:0] pick the destination: 4 = registers via reg4, 5 = table via reg5, 6 = discarded via reg6. That value is stored in reg7. When bit 3 is set, the next argument loads the chosen pointer. Each remaining byte is written at the pointer, which then post-increments.
- R6: An opcode-5 destination outside 4..6 sets error bit 1 (8'h02). The rest of that message is ignored and reg7 keeps its value.
- R7: Opcode 0 copies up to 3 arguments into regs 11..13. Opcode 2 copies up to 3 into regs 8..10. Opcode 7 copies up to 2 into regs 17..18. Opcode 8 copies argument 0 into reg19.
- R8: For opcode 2, a coarse argument greater than reg16 is stored as reg16 and sets error bit 2 (8'h04).
- R9: In the cycle after a message's last byte is accepted, exactly one strobe pulses for one cycle: opcode 0 gives `pwm_upd`, 1 gives `note_on_vel`, 2 gives `note_on_time`, 3 gives `note_off` and 6 gives `persist_req`.
- R10: An opcode of 9 or more changes no register and raises no strobe.
- R11: Only the first 16 argument bytes of a message are used. Later bytes have no effect.
- R12: Reg14 follows `state_in`. Messages cannot write reg14 or reg15 (the error register). Error bits only accumulate by OR, including two error sources in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Message byte present |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | Final byte of the message |
| rd_req | input | 1 | Request one read byte |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| state_in | input | 2 | Attack/hold state mirrored into reg14 |
| pwm_upd | output | 1 | PWM settings changed |
| note_on_vel | output | 1 | Note on by velocity |
| note_on_time | output | 1 | Note on by time |
| note_off | output | 1 | Note off |
| persist_req | output | 1 | Save table request |
| err_flags | output | 8 | Sticky error bits (reg15) |

## Verification
A read request and a message byte can fall in the same cycle. Both update the shared register file, and both can set error bits. The bench provokes this by pointing reg3 at an invalid source and raising `rd_req` in the cycle that a note-on coarse argument above the limit arrives. It then expects `err_flags` to hold both 8'h01 and 8'h04, no `rd_valid`, and the clamped coarse value.

// File: rtl/cmd_decoder.sv
module cmd_decoder #(
  parameter int REGS     = 20,
  parameter int TAW      = 8,
  parameter int MAX_ARGS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       rd_req,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  input  logic [1:0] state_in,
  output logic       pwm_upd,
  output logic       note_on_vel,
  output logic       note_on_time,
  output logic       note_off,
  output logic       persist_req,
  output logic [7:0] err_flags
);
  localparam int TBL_N = 1 << TAW;
  localparam int RW    = $clog2(REGS);
  localparam int CW    = $clog2(MAX_ARGS + 2);

  logic [7:0] regs [REGS];
  logic [7:0] nxt  [REGS];
  logic [7:0] tbl  [TBL_N];
  logic [CW-1:0] cnt;
  logic [RW-1:0] kk, p;
  logic [7:0] op, a, ra, rd_val, eop, tbl_wd;
  logic [2:0] err_set;
  logic [TAW-1:0] tbl_wa;
  logic abort_q, addr_fl, abort_set, fl_set, tbl_we, rd_fire, msg_end;

  function automatic logic [7:0] rst_val(int i);
    case (i)
      7:  return 8'd4;
      8:  return 8'd5;
      10: return 8'd4;
      11: return 8'd127;
      12: return 8'd255;
      13: return 8'd5;
      16: return 8'd14;
      18: return 8'd250;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic wr_ok(logic [7:0] x);
    return (x < REGS) && (x != 8'd14) && (x != 8'd15);
  endfunction

  assign kk        = RW'(cnt - 1'b1);
  assign msg_end   = in_valid && in_last;
  assign eop       = (cnt == '0) ? in_data : op;
  assign err_flags = regs[15];

  always_comb begin
    nxt = regs;
    err_set = '0; tbl_we = 1'b0; tbl_wa = '0; tbl_wd = '0;
    rd_fire = 1'b0; rd_val = '0; abort_set = 1'b0; fl_set = 1'b0;
    p = '0; a = '0; ra = '0;
    if (rd_req) begin
      case (regs[3])
        8'd0: begin
          ra = regs[0];
          rd_val = (ra < REGS) ? regs[ra[RW-1:0]] : 8'h00;
          nxt[0] = ra + 1'b1; rd_fire = 1'b1;
        end
        8'd1: begin
          rd_val = tbl[regs[1][TAW-1:0]];
          nxt[1] = regs[1] + 1'b1; rd_fire = 1'b1;
        end
        8'd2: begin
          rd_val = 8'hFF;
          nxt[2] = regs[2] + 1'b1; rd_fire = 1'b1;
        end
        default: err_set[0] = 1'b1;
      endcase
    end
    if (in_valid && cnt != '0 && cnt <= MAX_ARGS && !abort_q) begin
      case (op)
        8'd0: if (kk < 3) nxt[RW'(11) + kk] = in_data;
        8'd2: begin
          if (kk == '0) begin
            if (in_data > regs[16]) begin
              nxt[8] = regs[16]; err_set[2] = 1'b1;
            end else nxt[8] = in_data;
          end else if (kk < 3) nxt[RW'(8) + kk] = in_data;
        end
        8'd4: begin
          if (kk == '0) nxt[3] = in_data;
          else if (kk == RW'(1) && wr_ok(regs[3])) nxt[regs[3][RW-1:0]] = in_data;
        end
        8'd5: begin
          if (kk == '0) begin
            if (in_data[2:0] < 3'd4 || in_data[2:0] > 3'd6) begin
              err_set[1] = 1'b1; abort_set = 1'b1;
            end else begin
              nxt[7] = {5'd0, in_data[2:0]}; fl_set = 1'b1;
            end
          end else if (kk == RW'(1) && addr_fl) begin
            nxt[regs[7][RW-1:0]] = in_data;
          end else begin
            p = regs[7][RW-1:0];
            a = regs[p];
            nxt[p] = a + 1'b1;
            if (p == RW'(4)) begin
              if (wr_ok(a)) nxt[a[RW-1:0]] = in_data;
            end else if (p == RW'(5)) begin
              tbl_we = 1'b1; tbl_wa = a[TAW-1:0]; tbl_wd = in_data;
            end else if (p != RW'(6)) err_set[1] = 1'b1;
          end
        end
        8'd7: if (kk < 2) nxt[RW'(17) + kk] = in_data;
        8'd8: if (kk == '0) nxt[19] = in_data;
        default: ;
      endcase
    end
    nxt[14] = {6'd0, state_in};
    nxt[15] = regs[15] | {5'd0, err_set};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < REGS; i++) regs[i] <= rst_val(i);
      for (int j = 0; j < TBL_N; j++) tbl[j] <= '0;
      cnt <= '0; op <= '0; abort_q <= 1'b0; addr_fl <= 1'b0;
      rd_valid <= 1'b0; rd_data <= '0;
      {pwm_upd, note_on_vel, note_on_time, note_off, persist_req} <= '0;
    end else begin
      regs <= nxt;
      if (tbl_we) tbl[tbl_wa] <= tbl_wd;
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= rd_val;
      pwm_upd      <= msg_end && eop == 8'd0;
      note_on_vel  <= msg_end && eop == 8'd1;
      note_on_time <= msg_end && eop == 8'd2;
      note_off     <= msg_end && eop == 8'd3;
      persist_req  <= msg_end && eop == 8'd6;
      if (in_valid) begin
        if (in_last) cnt <= '0;
        else if (cnt <= MAX_ARGS) cnt <= cnt + 1'b1;
        if (cnt == '0) begin
          op <= in_data; abort_q <= 1'b0; addr_fl <= 1'b0;
        end else begin
          if (abort_set) abort_q <= 1'b1;
          if (fl_set) addr_fl <= in_data[3];
        end
      end
    end
  end
endmodule

// File: rtl/cmd_decoder_chk.sv
module cmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_last,
  input logic       rd_req,
  input logic       rd_valid,
  input logic       pwm_upd,
  input logic       note_on_vel,
  input logic       note_on_time,
  input logic       note_off,
  input logic       persist_req,
  input logic [7:0] err_flags
);
  a_r2_rdvalid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_req));
  a_r9_strobe_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_upd || note_on_vel || note_on_time || note_off || persist_req) |-> $past(in_valid && in_last));
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pwm_upd, note_on_vel, note_on_time, note_off, persist_req}));
  a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_flags) & ~err_flags) == 8'h00);
endmodule

bind cmd_decoder cmd_decoder_chk u_chk (.*);

// File: tb/sim_cmd_decoder.sv
module sim_cmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] RST_EXP [20] = '{8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd4,
    8'd5, 8'd0, 8'd4, 8'd127, 8'd255, 8'd5, 8'd0, 8'd0, 8'd14, 8'd0, 8'd250, 8'd0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, rd_req = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] state_in = '0;
  logic rd_valid, pwm_upd, note_on_vel, note_on_time, note_off, persist_req;
  logic [7:0] rd_data, err_flags;
  logic [4:0] stb;
  logic got_v;
  logic [7:0] got_d;
  int errors = 0, checks = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_decoder u0 (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(int n, logic [7:0] b0 = 0, logic [7:0] b1 = 0, logic [7:0] b2 = 0,
                      logic [7:0] b3 = 0, logic [7:0] b4 = 0, logic [7:0] b5 = 0);
    logic [7:0] m [6];
    m = '{b0, b1, b2, b3, b4, b5};
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = m[i]; in_last = (i == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    stb = {pwm_upd, note_on_vel, note_on_time, note_off, persist_req};
  endtask

  task automatic rd();
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    got_v = rd_valid; got_d = rd_data;
  endtask

  task automatic rdreg(logic [7:0] addr);
    send(3, 8'd4, 8'd0, addr);
    rd();
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 err", err_flags, 8'h00);
    chk("R1 strobes", {3'b0, pwm_upd, note_on_vel, note_on_time, note_off, persist_req}, 8'h00);
    chk("R1 rd_valid", {7'b0, rd_valid}, 8'h00);
    for (int i = 0; i < 20; i++) begin
      rdreg(8'(i));
      chk($sformatf("R1 reg%0d", i), got_d, RST_EXP[i]);
    end

    send(4, 8'd0, 8'd10, 8'd20, 8'd3);
    chk("R9 pwm strobe", {3'b0, stb}, 8'b10000);
    rdreg(8'd11); chk("R7 reg11", got_d, 8'd10);
    rd();         chk("R2 autoinc reg12", got_d, 8'd20);
    rd();         chk("R7 reg13", got_d, 8'd3);

    send(3, 8'd2, 8'd20, 8'd7);
    chk("R9 time strobe", {3'b0, stb}, 8'b00100);
    chk("R8 err", err_flags, 8'h04);
    rdreg(8'd8); chk("R8 clamp", got_d, 8'd14);
    rd();        chk("R7 reg9", got_d, 8'd7);

    send(5, 8'd5, 8'h0C, 8'd17, 8'd1, 8'd2);
    rdreg(8'd17); chk("R5 reg17", got_d, 8'd1);
    rd();         chk("R5 reg18", got_d, 8'd2);
    rdreg(8'd4);  chk("R5 wptr", got_d, 8'd19);

    send(5, 8'd5, 8'h0D, 8'd40, 8'hAA, 8'hBB);
    send(3, 8'd4, 8'd1, 8'd40);
    rd(); chk("R2 tbl40", got_d, 8'hAA);
    rd(); chk("R2 tbl41", got_d, 8'hBB);
    rdreg(8'd5); chk("R5 tbl wptr", got_d, 8'd42);
    rdreg(8'd1); chk("R4 tbl rptr", got_d, 8'd42);

    send(2, 8'd4, 8'd2);
    rd(); chk("R2 stub valid", {7'b0, got_v}, 8'h01);
    chk("R2 stub data", got_d, 8'hFF);

    send(4, 8'd5, 8'h03, 8'd1, 8'd2);
    chk("R6 err", err_flags, 8'h06);
    rdreg(8'd7); chk("R6 reg7 kept", got_d, 8'd5);

    send(2, 8'd4, 8'd3);
    rd(); chk("R3 no valid", {7'b0, got_v}, 8'h00);
    chk("R3 err", err_flags, 8'h07);

    send(4, 8'd9, 8'd1, 8'd2, 8'd3);
    chk("R10 no strobe", {3'b0, stb}, 8'h00);
    rdreg(8'd11); chk("R10 reg11", got_d, 8'd10);
    rdreg(8'd3);  chk("R10 reg3", got_d, 8'd0);

    send(3, 8'd7, 8'd3, 8'd4);
    rdreg(8'd17); chk("R7 hold c", got_d, 8'd3);
    rd();         chk("R7 hold f", got_d, 8'd4);
    send(2, 8'd8, 8'h5A);
    rdreg(8'd19); chk("R7 flags", got_d, 8'h5A);

    send(1, 8'd3); chk("R9 off strobe", {3'b0, stb}, 8'b00010);
    send(1, 8'd1); chk("R9 vel strobe", {3'b0, stb}, 8'b01000);
    send(1, 8'd6); chk("R9 persist strobe", {3'b0, stb}, 8'b00001);

    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_last = (i == 19);
      in_data = (i == 0) ? 8'd5 : (i == 1) ? 8'h0D : (i == 2) ? 8'd100 : 8'(i - 3);
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    rdreg(8'd5); chk("R11 wptr", got_d, 8'd114);
    send(3, 8'd4, 8'd1, 8'd113);
    rd(); chk("R11 last kept", got_d, 8'd13);
    rd(); chk("R11 dropped", got_d, 8'd0);

    state_in = 2'b10;
    send(5, 8'd5, 8'h0C, 8'd14, 8'h33, 8'h44);
    rdreg(8'd14); chk("R12 state mirror", got_d, 8'd2);
    rd();         chk("R12 err not writable", got_d, 8'h07);
    chk("R12 err port", err_flags, 8'h07);

    do_reset();
    send(2, 8'd4, 8'd5);
    @(negedge clk); in_valid = 1'b1; in_data = 8'd2; in_last = 1'b0;
    @(negedge clk); in_data = 8'd50; in_last = 1'b1; rd_req = 1'b1;
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0; rd_req = 1'b0;
    chk("R12 same-cycle no valid", {7'b0, rd_valid}, 8'h00);
    chk("R9 same-cycle strobe", {7'b0, note_on_time}, 8'h01);
    chk("R12 same-cycle err merge", err_flags, 8'h05);
    rdreg(8'd8); chk("R8 same-cycle clamp", got_d, 8'd14);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule